// File: doc/BRIEF.md
# Interrupt Request Selection Unit

This unit sits next to a small 16-bit processor core. At every instruction boundary it decides whether the core takes an interrupt, and if so which 8-bit type number to use. It looks at several kinds of source:

- exceptions and software interrupt instructions that complete in the boundary cycle;
- a latched non-maskable request;
- a maskable request line, gated by the interrupt flag;
- single-stepping, driven by the trap flag.

The result is a one-cycle take pulse that carries the selected type. The core uses that type to index its vector table.

A maskable request does not carry its own type. The unit runs a fixed two-cycle acknowledge exchange and reads the type from an external 8-bit data bus during the second cycle. The core stalls while this runs, and boundary strobes are ignored until it completes. Resolving priority among several external devices is left to an external controller. Pushing and popping state on the stack belongs to the core.

Top module: `irq_type_select`

## Requirements
- R1: While reset is high, and in the first cycle after it, `take_o`, `inta_o` and `type_o` are all zero.
- R2: Instruction-boundary sources are sampled on a clock edge where `boundary_i` is 1. They produce `take_o`=1 in the following cycle, with these types:
  - divide error gives type 0;
  - breakpoint gives type 3;
  - software interrupt gives its 8-bit immediate `swi_type_i`;
  - overflow-conditional gives type 4, but only when `ovf_flag_i` is 1.
- R3: If several instruction-boundary sources are present at once, the order is divide error, then breakpoint, then software interrupt, then overflow-conditional.
- R4: A rising edge on `nmi_i` is latched even between boundaries. At the next boundary it is taken as type 2, whatever `if_flag_i` holds. One pulse gives exactly one take.
- R5: A maskable request on `intr_i` is accepted at a boundary only when `if_flag_i` is 1. Otherwise it produces nothing and stays pending for as long as the line is held.
- R6: The acknowledge exchange works as follows:
  - an accepted maskable request raises `inta_o` for exactly two cycles, starting the cycle after the boundary;
  - `data_i` is sampled at the end of the second cycle;
  - `take_o` is 1 in the next cycle, with `type_o` equal to that byte.
- R7: With `tf_flag_i` = 1 and no other source, a boundary yields type 1.
- R8: Priority between classes is instruction-boundary source, then NMI, then maskable, then single-step. Only the winner is reported. A latched NMI that loses is taken at a later boundary.
- R9: Boundary strobes that arrive while `inta_o` is high are ignored, and `take_o` is never 1 while `inta_o` is 1.
- R10: `type_o` is zero whenever `take_o` is zero.
- R11: Without a boundary strobe and with no acknowledge exchange running, `take_o` stays 0 even with requests present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary_i | input | 1 | The current instruction completes this cycle |
| nmi_i | input | 1 | Non-maskable request line, edge-sensitive |
| intr_i | input | 1 | Maskable request line, level-sensitive |
| div_err_i | input | 1 | Divide error at this boundary |
| brk_i | input | 1 | Single-byte breakpoint opcode completed |
| swi_i | input | 1 | Software interrupt instruction completed |
| swi_type_i | input | 8 | Immediate type of the software interrupt |
| into_i | input | 1 | Overflow-conditional instruction completed |
| ovf_flag_i | input | 1 | Overflow flag |
| if_flag_i | input | 1 | Interrupt flag |
| tf_flag_i | input | 1 | Trap (single-step) flag |
| data_i | input | 8 | Type byte driven by the acknowledged device |
| inta_o | output | 1 | Interrupt acknowledge |
| take_o | output | 1 | One-cycle take-interrupt pulse |
| type_o | output | 8 | Selected type number |

## Verification
The assertions check the following on every cycle:
- the shape of the acknowledge exchange: its two-cycle length, that it starts only from an enabled maskable request at a boundary, and that it ends with a take carrying the sampled byte;
- that a take never overlaps acknowledge;
- that the type is zero when idle;
- that every take traces back to a boundary or to the end of an acknowledge.

Some behaviours only the directed scenarios can show: the type numbers chosen for each source, the priority order within and between classes, that a latched NMI is taken exactly once, that a masked request stays pending, and that boundaries are ignored during acknowledge.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;

    localparam int TYPE_W = 8;

    typedef logic [TYPE_W-1:0] irq_type_t;

    localparam irq_type_t T_DIVIDE = 8'd0;
    localparam irq_type_t T_STEP   = 8'd1;
    localparam irq_type_t T_NMI    = 8'd2;
    localparam irq_type_t T_BREAK  = 8'd3;
    localparam irq_type_t T_OVFL   = 8'd4;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_EXC,
        SRC_NMI,
        SRC_MASK,
        SRC_STEP
    } irq_src_e;

    typedef struct packed {
        irq_src_e  src;
        irq_type_t vec;
    } irq_pick_t;

    typedef enum logic [1:0] {
        ACK_IDLE,
        ACK_ONE,
        ACK_TWO
    } ack_state_e;

    // Instruction-boundary group: fixed internal order.
    function automatic irq_pick_t pick_exception(
        input logic      div_err,
        input logic      brk,
        input logic      swi,
        input irq_type_t swi_type,
        input logic      into,
        input logic      ovf
    );
        irq_pick_t p;
        p.src = SRC_EXC;
        p.vec = '0;
        if (div_err)          p.vec = T_DIVIDE;
        else if (brk)         p.vec = T_BREAK;
        else if (swi)         p.vec = swi_type;
        else if (into && ovf) p.vec = T_OVFL;
        else                  p.src = SRC_NONE;
        return p;
    endfunction

endpackage

// File: rtl/irqsel_nmi_latch.sv
module irqsel_nmi_latch (
    input  logic clk,
    input  logic rst,
    input  logic nmi_i,
    input  logic clear_i,
    output logic pend_o
);
    logic nmi_q;
    logic rise;

    assign rise = nmi_i & ~nmi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_q  <= 1'b0;
            pend_o <= 1'b0;
        end else begin
            nmi_q <= nmi_i;
            // a fresh edge wins over the clear of an older one
            if (rise)         pend_o <= 1'b1;
            else if (clear_i) pend_o <= 1'b0;
        end
    end
endmodule

// File: rtl/irqsel_arbiter.sv
module irqsel_arbiter
    import irqsel_pkg::*;
(
    input  logic      div_err_i,
    input  logic      brk_i,
    input  logic      swi_i,
    input  irq_type_t swi_type_i,
    input  logic      into_i,
    input  logic      ovf_flag_i,
    input  logic      nmi_pend_i,
    input  logic      intr_i,
    input  logic      if_flag_i,
    input  logic      tf_flag_i,
    output irq_pick_t pick_o
);
    irq_pick_t exc;

    always_comb begin
        exc = pick_exception(div_err_i, brk_i, swi_i, swi_type_i,
                             into_i, ovf_flag_i);
        if (exc.src != SRC_NONE) begin
            pick_o = exc;
        end else if (nmi_pend_i) begin
            pick_o = '{src: SRC_NMI, vec: T_NMI};
        end else if (intr_i && if_flag_i) begin
            pick_o = '{src: SRC_MASK, vec: '0};
        end else if (tf_flag_i) begin
            pick_o = '{src: SRC_STEP, vec: T_STEP};
        end else begin
            pick_o = '{src: SRC_NONE, vec: '0};
        end
    end
endmodule

// File: rtl/irqsel_ack_seq.sv
module irqsel_ack_seq
    import irqsel_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic busy_o,
    output logic sample_o
);
    ack_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ACK_IDLE;
        end else begin
            unique case (state)
                ACK_IDLE: if (start_i) state <= ACK_ONE;
                ACK_ONE:  state <= ACK_TWO;
                ACK_TWO:  state <= ACK_IDLE;
                default:  state <= ACK_IDLE;
            endcase
        end
    end

    assign busy_o   = (state != ACK_IDLE);
    assign sample_o = (state == ACK_TWO);
endmodule

// File: rtl/irq_type_select.sv
module irq_type_select
    import irqsel_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                boundary_i,
    input  logic                nmi_i,
    input  logic                intr_i,
    input  logic                div_err_i,
    input  logic                brk_i,
    input  logic                swi_i,
    input  logic [TYPE_W-1:0]   swi_type_i,
    input  logic                into_i,
    input  logic                ovf_flag_i,
    input  logic                if_flag_i,
    input  logic                tf_flag_i,
    input  logic [TYPE_W-1:0]   data_i,
    output logic                inta_o,
    output logic                take_o,
    output logic [TYPE_W-1:0]   type_o
);
    logic      nmi_pend;
    logic      accept;
    logic      ack_busy;
    logic      ack_sample;
    irq_pick_t pick;

    assign accept = boundary_i & ~ack_busy;

    irqsel_nmi_latch u_nmi (
        .clk     (clk),
        .rst     (rst),
        .nmi_i   (nmi_i),
        .clear_i (accept && pick.src == SRC_NMI),
        .pend_o  (nmi_pend)
    );

    irqsel_arbiter u_arb (
        .div_err_i  (div_err_i),
        .brk_i      (brk_i),
        .swi_i      (swi_i),
        .swi_type_i (swi_type_i),
        .into_i     (into_i),
        .ovf_flag_i (ovf_flag_i),
        .nmi_pend_i (nmi_pend),
        .intr_i     (intr_i),
        .if_flag_i  (if_flag_i),
        .tf_flag_i  (tf_flag_i),
        .pick_o     (pick)
    );

    irqsel_ack_seq u_ack (
        .clk      (clk),
        .rst      (rst),
        .start_i  (accept && pick.src == SRC_MASK),
        .busy_o   (ack_busy),
        .sample_o (ack_sample)
    );

    assign inta_o = ack_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            take_o <= 1'b0;
            type_o <= '0;
        end else if (ack_sample) begin
            take_o <= 1'b1;
            type_o <= data_i;
        end else if (accept && pick.src != SRC_NONE && pick.src != SRC_MASK) begin
            take_o <= 1'b1;
            type_o <= pick.vec;
        end else begin
            take_o <= 1'b0;
            type_o <= '0;
        end
    end
endmodule

// File: rtl/irqsel_checks.sv
module irqsel_checks (
    input logic       clk,
    input logic       rst,
    input logic       boundary_i,
    input logic       intr_i,
    input logic       if_flag_i,
    input logic [7:0] data_i,
    input logic       inta_o,
    input logic       take_o,
    input logic [7:0] type_o
);
    assert_ack_hold_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(inta_o) |=> inta_o);

    assert_ack_end_R6: assert property (@(posedge clk) disable iff (rst)
        (inta_o && $past(inta_o)) |=> !inta_o);

    assert_ack_type_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(inta_o) |-> (take_o && type_o == $past(data_i)));

    assert_ack_gate_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(inta_o) |-> $past(intr_i && if_flag_i && boundary_i));

    assert_ack_excl_R9: assert property (@(posedge clk) disable iff (rst)
        inta_o |-> !take_o);

    assert_type_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !take_o |-> (type_o == 8'd0));

    assert_take_cause_R11: assert property (@(posedge clk) disable iff (rst)
        take_o |-> ($past(boundary_i) || $past(inta_o)));
endmodule

bind irq_type_select irqsel_checks u_irqsel_checks (
    .clk        (clk),
    .rst        (rst),
    .boundary_i (boundary_i),
    .intr_i     (intr_i),
    .if_flag_i  (if_flag_i),
    .data_i     (data_i),
    .inta_o     (inta_o),
    .take_o     (take_o),
    .type_o     (type_o)
);

// File: tb/test_irq_type_select.sv
module test_irq_type_select;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       boundary_i = 0, nmi_i = 0, intr_i = 0;
    logic       div_err_i = 0, brk_i = 0, swi_i = 0, into_i = 0;
    logic       ovf_flag_i = 0, if_flag_i = 0, tf_flag_i = 0;
    logic [7:0] swi_type_i = 0, data_i = 0;
    logic       inta_o, take_o;
    logic [7:0] type_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    irq_type_select i_irq_type_select (
        .clk(clk), .rst(rst), .boundary_i(boundary_i), .nmi_i(nmi_i),
        .intr_i(intr_i), .div_err_i(div_err_i), .brk_i(brk_i),
        .swi_i(swi_i), .swi_type_i(swi_type_i), .into_i(into_i),
        .ovf_flag_i(ovf_flag_i), .if_flag_i(if_flag_i),
        .tf_flag_i(tf_flag_i), .data_i(data_i), .inta_o(inta_o),
        .take_o(take_o), .type_o(type_o)
    );

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic chk_take(input string tag, input logic et, input logic [7:0] ety);
        chk(tag, "take_o", int'(take_o), int'(et));
        chk(tag, "type_o", int'(type_o), int'(ety));
    endtask

    // one boundary; instruction strobes are cleared after the edge
    task automatic boundary;
        boundary_i = 1;
        tick();
        boundary_i = 0; div_err_i = 0; brk_i = 0; swi_i = 0; into_i = 0;
        swi_type_i = 0;
    endtask

    task automatic t_reset;
        chk("R1", "inta_o", int'(inta_o), 0);
        chk_take("R1", 1'b0, 8'h00);
        rst = 0;
        tick();
        chk("R1", "inta_o after release", int'(inta_o), 0);
        chk_take("R1", 1'b0, 8'h00);
    endtask

    task automatic t_exceptions;
        div_err_i = 1; boundary(); chk_take("R2 div", 1'b1, 8'h00);
        brk_i = 1;     boundary(); chk_take("R2 brk", 1'b1, 8'h03);
        swi_i = 1; swi_type_i = 8'h21; boundary(); chk_take("R2 swi", 1'b1, 8'h21);
        swi_i = 1; swi_type_i = 8'h04; boundary(); chk_take("R2 swi4", 1'b1, 8'h04);
        into_i = 1; ovf_flag_i = 1; boundary(); chk_take("R2 into ovf", 1'b1, 8'h04);
        into_i = 1; ovf_flag_i = 0; boundary(); chk_take("R2 into clr", 1'b0, 8'h00);
        tick(); chk_take("R10 idle", 1'b0, 8'h00);
    endtask

    task automatic t_exc_order;
        div_err_i = 1; swi_i = 1; swi_type_i = 8'h55; brk_i = 1;
        boundary(); chk_take("R3 div first", 1'b1, 8'h00);
        brk_i = 1; swi_i = 1; swi_type_i = 8'h55;
        boundary(); chk_take("R3 brk over swi", 1'b1, 8'h03);
        swi_i = 1; swi_type_i = 8'h9A; into_i = 1; ovf_flag_i = 1;
        boundary(); chk_take("R3 swi over into", 1'b1, 8'h9A);
        ovf_flag_i = 0;
    endtask

    task automatic t_nmi;
        if_flag_i = 0;
        nmi_i = 1; tick(); nmi_i = 0;
        for (int k = 0; k < 3; k++) begin
            tick(); chk_take("R11 no boundary", 1'b0, 8'h00);
        end
        boundary(); chk_take("R4 nmi taken", 1'b1, 8'h02);
        boundary(); chk_take("R4 nmi once", 1'b0, 8'h00);
    endtask

    task automatic t_maskable;
        intr_i = 1; if_flag_i = 0;
        boundary(); chk_take("R5 masked", 1'b0, 8'h00);
        chk("R5", "inta_o masked", int'(inta_o), 0);
        boundary(); chk("R5", "inta_o still masked", int'(inta_o), 0);
        if_flag_i = 1;
        boundary();
        chk("R6", "inta_o cycle 1", int'(inta_o), 1);
        chk_take("R9 no take in ack", 1'b0, 8'h00);
        intr_i = 0; data_i = 8'hFF; boundary_i = 1; tf_flag_i = 1;
        tick();
        boundary_i = 0; tf_flag_i = 0; data_i = 8'h47;
        chk("R6", "inta_o cycle 2", int'(inta_o), 1);
        chk_take("R9 no take in ack", 1'b0, 8'h00);
        tick();
        data_i = 8'h00;
        chk("R6", "inta_o done", int'(inta_o), 0);
        chk_take("R6 fetched type", 1'b1, 8'h47);
        tick();
        chk_take("R9 ignored boundary", 1'b0, 8'h00);
        if_flag_i = 0;
    endtask

    task automatic t_trap;
        tf_flag_i = 1; boundary(); chk_take("R7 step", 1'b1, 8'h01);
        boundary(); chk_take("R7 step again", 1'b1, 8'h01);
        tf_flag_i = 0; boundary(); chk_take("R7 off", 1'b0, 8'h00);
    endtask

    task automatic t_mixed;
        nmi_i = 1; tick(); nmi_i = 0;
        intr_i = 1; if_flag_i = 1; tf_flag_i = 1;
        swi_i = 1; swi_type_i = 8'h80;
        boundary(); chk_take("R8 exc wins", 1'b1, 8'h80);
        boundary(); chk_take("R8 nmi next", 1'b1, 8'h02);
        boundary();
        chk("R8", "maskable over step", int'(inta_o), 1);
        tick(); data_i = 8'h33;
        tick(); data_i = 8'h00;
        chk_take("R8 maskable type", 1'b1, 8'h33);
        intr_i = 0;
        boundary(); chk_take("R8 step last", 1'b1, 8'h01);
        tf_flag_i = 0; if_flag_i = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        t_exceptions();
        t_exc_order();
        t_nmi();
        t_maskable();
        t_trap();
        t_mixed();
        tick();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule